// File: doc/BRIEF.md
# Token-Passing Chain Readout Controller

This block reads out a chain of front-end chip nodes that share one output bus. A token passes along the chain, and only the node that holds the token may use the bus. Each node keeps a small store of event payloads. The bench loads these stores before a readout. A start pulse gives the token to node 0. The node that holds the token sends its stored words one per cycle, then hands the token to the next node.

When the token arrives at a node, that node's digital power line turns on. The line stays on until the whole chain has finished. The node's clock-and-buffer enable is high only while the node holds the token. A node with an empty store still takes the token and passes it on at once. A runtime limit sets the longest window a node may keep the token, counted in words. When the window expires, the token passes even if words remain. Each bus word carries the sending node's index in its upper bits.

Top module: `chain_readout`

## Requirements
- R1: While reset is held and right after it is released, `bus_vld`, `chain_done`, `node_eor`, `dig_pwr` and `clk_en` are all 0.
- R2: A `start_rd` pulse seen at a rising edge while the chain is idle gives node 0 the token. `clk_en[0]` and `dig_pwr[0]` are 1 in the cycle after that edge.
- R3: Nodes are read in ascending index order. Let a node hold `c` stored words, with `c` not above `rd_limit`. That node sends its words in load order, one per cycle, starting in its first token cycle. It raises `node_eor` in its token cycle number `c`, counting from 0. The next node holds the token in the following cycle.
- R4: A node with no stored words holds the token for exactly one cycle. In that cycle it raises `node_eor` and does not assert `bus_vld`.
- R5: `bus_word[WORD_W-1:PAY_W]` is the sending node's index, and `bus_word[PAY_W-1:0]` is the stored payload.
- R6: At most one node drives the bus in any cycle. When `bus_vld` is 0, `bus_word` is 0.
- R7: A node's `dig_pwr` turns on in the first cycle it holds the token and stays on while later nodes are read. Its `clk_en` is 1 only in the cycles where it holds the token.
- R8: A node that holds more than `rd_limit` words sends only the first `rd_limit` words. It raises `node_eor` in its token cycle number `rd_limit`. The words it did not send are discarded.
- R9: `chain_done` is a one-cycle pulse in the cycle after the last node raises `node_eor`. In that cycle, all `dig_pwr` bits are 0.
- R10: A `start_rd` pulse that arrives while a readout is in progress has no effect on the token sequence or on the bus.
- R11: Each node stores at most DEPTH words, and further loads are dropped. Loads made while a readout is in progress are dropped. A node's store is empty after its readout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_limit | input | TMO_W | Most words one node may send per token visit (held stable during readout, at least 1) |
| ld_en | input | 1 | Load strobe for a node's store |
| ld_node | input | IDX_W | Target node of a load |
| ld_data | input | PAY_W | Payload to store |
| start_rd | input | 1 | Start-readout pulse |
| bus_vld | output | 1 | Shared bus carries a word |
| bus_word | output | WORD_W | Node index (upper bits) and payload (lower bits) |
| node_eor | output | N_NODES | Per-node end-of-readout, high in the node's last token cycle |
| dig_pwr | output | N_NODES | Per-node digital power line |
| clk_en | output | N_NODES | Per-node clock and output-buffer enable |
| chain_done | output | 1 | One-cycle pulse after the last node finishes |

## Verification
The bench fixes each node's token window from its word count and the limit. Node `i` starts at the sum of the earlier windows, measured from the cycle after the accepted start edge, and a window lasts `min(c, rd_limit) + 1` cycles. From this the bench knows, for every cycle, the expected token holder, bus word, end-of-readout bit, power mask and done pulse. It samples all outputs on the falling edge of each cycle, starting with the first cycle after the start edge and ending two cycles past `chain_done`. Late start pulses and loads are driven at falling edges during a readout. Their absence of effect is then checked cycle by cycle in that readout, and again in the next readout.

// File: rtl/chain_readout_pkg.sv
package chain_readout_pkg;

  // Number of words a node sends in one token visit.
  function automatic int words_due(input int stored, input int limit);
    return (stored < limit) ? stored : limit;
  endfunction

  // Token cycles a node occupies: its words plus one handover cycle.
  function automatic int visit_len(input int stored, input int limit);
    return words_due(stored, limit) + 1;
  endfunction

endpackage

// File: rtl/chain_node.sv
module chain_node
  import chain_readout_pkg::*;
#(
  parameter int NODE_ID = 0,
  parameter int N_NODES = 24,
  parameter int DEPTH   = 16,
  parameter int PAY_W   = 16,
  parameter int TMO_W   = 12,
  localparam int IDX_W  = (N_NODES > 1) ? $clog2(N_NODES) : 1,
  localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int WORD_W = IDX_W + PAY_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chain_act,
  input  logic [TMO_W-1:0]  rd_limit,
  input  logic              ld_en,
  input  logic [IDX_W-1:0]  ld_node,
  input  logic [PAY_W-1:0]  ld_data,
  input  logic              tok_in,
  input  logic              pwr_clr,
  output logic              tok_out,
  output logic              holding,
  output logic              pwr,
  output logic              vld,
  output logic [WORD_W-1:0] word
);

  logic [PAY_W-1:0] store [DEPTH];
  logic             hold_q;
  logic             pwr_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] rd_q;
  logic [TMO_W-1:0] tmr_q;

  // Named internal events, visible to the assertions below.
  logic ld_ok;
  logic store_empty;
  logic window_spent;
  logic release_w;
  logic drive_w;

  assign ld_ok        = ld_en && !chain_act && (ld_node == IDX_W'(NODE_ID))
                        && (cnt_q != CNT_W'(DEPTH));
  assign store_empty  = (rd_q == cnt_q);
  assign window_spent = (tmr_q == rd_limit);
  assign release_w    = hold_q && (store_empty || window_spent);
  assign drive_w      = hold_q && !release_w;

  always_ff @(posedge clk) begin
    if (ld_ok) store[cnt_q[AW-1:0]] <= ld_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      pwr_q  <= 1'b0;
      cnt_q  <= '0;
      rd_q   <= '0;
      tmr_q  <= '0;
    end else begin
      if (tok_in) begin
        hold_q <= 1'b1;
        rd_q   <= '0;
        tmr_q  <= '0;
      end else if (release_w) begin
        hold_q <= 1'b0;
        rd_q   <= '0;
        tmr_q  <= '0;
        cnt_q  <= '0;
      end else if (drive_w) begin
        rd_q   <= rd_q + 1'b1;
        tmr_q  <= tmr_q + 1'b1;
      end
      if (ld_ok) cnt_q <= cnt_q + 1'b1;
      if (tok_in) pwr_q <= 1'b1;
      else if (pwr_clr) pwr_q <= 1'b0;
    end
  end

  assign tok_out = release_w;
  assign holding = hold_q;
  assign pwr     = pwr_q;
  assign vld     = drive_w;
  assign word    = drive_w ? {IDX_W'(NODE_ID), store[rd_q[AW-1:0]]} : '0;

  // R7: a node only drives with its power line and clock enable on
  p_drive_powered_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vld |-> (pwr && holding));

  // R8: the token leaves exactly when the visit's word budget is used
  p_release_due_r8: assert property (@(posedge clk) disable iff (!rst_n)
    release_w |-> (int'(tmr_q) == words_due(int'(cnt_q), int'(rd_limit))));

  // R8: the window counter never passes the limit
  p_window_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |-> (tmr_q <= rd_limit));

  // R11: the store is empty once the token has left
  p_store_cleared_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (release_w && !tok_in) |=> (cnt_q == '0));

endmodule

// File: rtl/chain_token_seq.sv
module chain_token_seq #(
  parameter int N_NODES = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_rd,
  input  logic [N_NODES-1:0] eor,
  output logic [N_NODES-1:0] tok,
  output logic               busy,
  output logic               pwr_clr,
  output logic               chain_done
);

  logic busy_q;
  logic done_q;
  logic start_ok;

  assign start_ok = start_rd && !busy_q;

  generate
    for (genvar i = 0; i < N_NODES; i++) begin : g_tok
      if (i == 0) begin : g_head
        assign tok[i] = start_ok;
      end else begin : g_link
        assign tok[i] = eor[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (start_ok) busy_q <= 1'b1;
      else if (eor[N_NODES-1]) busy_q <= 1'b0;
      done_q <= eor[N_NODES-1];
    end
  end

  assign busy       = busy_q;
  assign pwr_clr    = eor[N_NODES-1];
  assign chain_done = done_q;

  // R9: the done indication lasts one cycle
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    chain_done |=> !chain_done);

  // R9: the chain is idle once done is signalled
  p_idle_at_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    chain_done |-> !busy_q);

endmodule

// File: rtl/chain_busmux.sv
module chain_busmux #(
  parameter int N_NODES = 24,
  parameter int WORD_W  = 21
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_NODES-1:0] vld,
  input  logic [WORD_W-1:0]  words [N_NODES],
  output logic               bus_vld,
  output logic [WORD_W-1:0]  bus_word
);

  always_comb begin
    bus_word = '0;
    for (int i = 0; i < N_NODES; i++) bus_word = bus_word | words[i];
  end

  assign bus_vld = |vld;

  // R6: no two nodes drive in the same cycle
  p_one_driver_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(vld));

  // R6: the bus is quiet when nothing is valid
  p_quiet_bus_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_vld |-> (bus_word == '0));

endmodule

// File: rtl/chain_readout.sv
module chain_readout #(
  parameter int N_NODES = 24,
  parameter int DEPTH   = 16,
  parameter int PAY_W   = 16,
  parameter int TMO_W   = 12,
  localparam int IDX_W  = (N_NODES > 1) ? $clog2(N_NODES) : 1,
  localparam int WORD_W = IDX_W + PAY_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [TMO_W-1:0]   rd_limit,
  input  logic               ld_en,
  input  logic [IDX_W-1:0]   ld_node,
  input  logic [PAY_W-1:0]   ld_data,
  input  logic               start_rd,
  output logic               bus_vld,
  output logic [WORD_W-1:0]  bus_word,
  output logic [N_NODES-1:0] node_eor,
  output logic [N_NODES-1:0] dig_pwr,
  output logic [N_NODES-1:0] clk_en,
  output logic               chain_done
);

  logic [N_NODES-1:0] tok;
  logic [N_NODES-1:0] eor;
  logic [N_NODES-1:0] hold;
  logic [N_NODES-1:0] pwr;
  logic [N_NODES-1:0] vld;
  logic [WORD_W-1:0]  words [N_NODES];
  logic               busy;
  logic               pwr_clr;

  chain_token_seq #(.N_NODES(N_NODES)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_rd(start_rd), .eor(eor), .tok(tok),
    .busy(busy), .pwr_clr(pwr_clr), .chain_done(chain_done)
  );

  generate
    for (genvar i = 0; i < N_NODES; i++) begin : g_node
      chain_node #(
        .NODE_ID(i), .N_NODES(N_NODES), .DEPTH(DEPTH),
        .PAY_W(PAY_W), .TMO_W(TMO_W)
      ) u_node (
        .clk(clk), .rst_n(rst_n), .chain_act(busy), .rd_limit(rd_limit),
        .ld_en(ld_en), .ld_node(ld_node), .ld_data(ld_data),
        .tok_in(tok[i]), .pwr_clr(pwr_clr), .tok_out(eor[i]),
        .holding(hold[i]), .pwr(pwr[i]), .vld(vld[i]), .word(words[i])
      );
    end
  endgenerate

  chain_busmux #(.N_NODES(N_NODES), .WORD_W(WORD_W)) u_mux (
    .clk(clk), .rst_n(rst_n), .vld(vld), .words(words),
    .bus_vld(bus_vld), .bus_word(bus_word)
  );

  assign node_eor = eor;
  assign dig_pwr  = pwr;
  assign clk_en   = hold;

  // R6: a single token is in the ring
  p_one_token_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hold));

  // R2: an accepted start puts the token on node 0
  p_head_gets_token_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_rd && !busy) |=> (clk_en[0] && dig_pwr[0]));

  // R10: a start during readout does not hand node 0 a token
  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start_rd && busy && !hold[0]) |=> !hold[0]);

  // R9: every power line is off when done is signalled
  p_pwr_off_at_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    chain_done |-> (dig_pwr == '0));

endmodule

// File: tb/chain_readout_tb.sv
module chain_readout_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NN  = 24;
  localparam int DEP = 8;
  localparam int PW  = 16;
  localparam int TW  = 12;
  localparam int IW  = 5;
  localparam int WW  = IW + PW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [TW-1:0] rd_limit = TW'(20);
  logic          ld_en = 1'b0;
  logic [IW-1:0] ld_node = '0;
  logic [PW-1:0] ld_data = '0;
  logic          start_rd = 1'b0;
  logic          bus_vld;
  logic [WW-1:0] bus_word;
  logic [NN-1:0] node_eor, dig_pwr, clk_en;
  logic          chain_done;

  int n_chk = 0;
  int n_err = 0;
  int exp_cnt [NN];
  logic [PW-1:0] exp_pay [NN][DEP];

  chain_readout #(.N_NODES(NN), .DEPTH(DEP), .PAY_W(PW), .TMO_W(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .rd_limit(rd_limit), .ld_en(ld_en),
    .ld_node(ld_node), .ld_data(ld_data), .start_rd(start_rd),
    .bus_vld(bus_vld), .bus_word(bus_word), .node_eor(node_eor),
    .dig_pwr(dig_pwr), .clk_en(clk_en), .chain_done(chain_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic load(input int node, input int n, input logic [PW-1:0] base);
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_node = IW'(node); ld_data = base + PW'(j);
      if (exp_cnt[node] < DEP) begin
        exp_pay[node][exp_cnt[node]] = base + PW'(j);
        exp_cnt[node]++;
      end
    end
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  // Runs one chain readout and checks every cycle against the model.
  task automatic run_chain(input string rtag, input int glitch_k, input int ld_k);
    int st [NN];
    int hl [NN];
    int lim;
    int tot;
    lim = int'(rd_limit);
    tot = 0;
    for (int i = 0; i < NN; i++) begin
      st[i] = tot;
      hl[i] = ((exp_cnt[i] < lim) ? exp_cnt[i] : lim) + 1;
      tot += hl[i];
    end
    @(negedge clk); start_rd = 1'b1;
    @(negedge clk); start_rd = 1'b0;
    for (int k = 0; k <= tot + 2; k++) begin
      int holder;
      int off;
      logic [NN-1:0] e_clk, e_eor, e_pwr;
      logic e_vld;
      logic [WW-1:0] e_word;
      string tv;
      if (k > 0) @(negedge clk);
      start_rd = (k == glitch_k);
      ld_en = (k == ld_k); ld_node = IW'(9); ld_data = 16'hDEAD;
      holder = -1;
      for (int i = 0; i < NN; i++)
        if (st[i] <= k && k < st[i] + hl[i]) holder = i;
      e_clk = '0; e_eor = '0; e_pwr = '0; e_vld = 1'b0; e_word = '0;
      if (k < tot)
        for (int i = 0; i < NN; i++) if (st[i] <= k) e_pwr[i] = 1'b1;
      tv = (rtag != "") ? rtag : "R3";
      if (holder >= 0) begin
        off = k - st[holder];
        e_clk[holder] = 1'b1;
        if (off < hl[holder] - 1) begin
          e_vld = 1'b1;
          e_word = {IW'(holder), exp_pay[holder][off]};
        end else begin
          e_eor[holder] = 1'b1;
        end
        if (rtag == "" && exp_cnt[holder] > lim) tv = "R8";
        if (rtag == "" && exp_cnt[holder] == 0) tv = "R4";
      end
      chk(bus_vld === e_vld, tv, $sformatf("bus_vld cycle %0d", k), 32'(bus_vld), 32'(e_vld));
      chk(bus_word === e_word, e_vld ? "R5" : "R6", $sformatf("bus_word cycle %0d", k),
          32'(bus_word), 32'(e_word));
      chk(node_eor === e_eor, tv, $sformatf("node_eor cycle %0d", k), 32'(node_eor), 32'(e_eor));
      chk(clk_en === e_clk, (k == 0) ? "R2" : "R7", $sformatf("clk_en cycle %0d", k),
          32'(clk_en), 32'(e_clk));
      chk(dig_pwr === e_pwr, (k >= tot) ? "R9" : "R7", $sformatf("dig_pwr cycle %0d", k),
          32'(dig_pwr), 32'(e_pwr));
      chk(chain_done === (k == tot), "R9", $sformatf("chain_done cycle %0d", k),
          32'(chain_done), 32'(k == tot));
    end
    start_rd = 1'b0; ld_en = 1'b0;
    for (int i = 0; i < NN; i++) exp_cnt[i] = 0;
  endtask

  task automatic t_reset;
    repeat (2) @(negedge clk);
    chk(bus_vld === 1'b0 && chain_done === 1'b0, "R1", "vld/done in reset",
        32'({bus_vld, chain_done}), 32'h0);
    chk(dig_pwr === '0 && clk_en === '0 && node_eor === '0, "R1", "lines in reset",
        32'(dig_pwr | clk_en | node_eor), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bus_vld === 1'b0 && dig_pwr === '0 && clk_en === '0, "R1", "after reset",
        32'(dig_pwr | clk_en), 32'h0);
  endtask

  // R3 R4 R5 R11: mixed counts, empty nodes, store overflow on node 3
  task automatic t_mixed;
    rd_limit = TW'(20);
    load(0, 3, 16'h1000);
    load(2, 1, 16'h2000);
    load(3, 10, 16'h3000);
    load(5, 2, 16'h5000);
    load(23, 4, 16'h7000);
    run_chain("", -1, -1);
  endtask

  // R8: limit shorter than some stores, one store exactly at the limit
  task automatic t_limit;
    rd_limit = TW'(5);
    load(4, 8, 16'h4400);
    load(7, 5, 16'h4700);
    load(8, 2, 16'h4800);
    run_chain("", -1, -1);
    rd_limit = TW'(20);
  endtask

  // R10 R11: start and load during an active readout have no effect
  task automatic t_busy_inputs;
    load(1, 4, 16'h6100);
    load(12, 3, 16'h6C00);
    run_chain("R10", 5, 3);
  endtask

  // R11: stores are empty after readout, and the in-flight load was dropped
  task automatic t_emptied;
    run_chain("R11", -1, -1);
  endtask

  initial begin
    for (int i = 0; i < NN; i++) exp_cnt[i] = 0;
    t_reset();
    t_mixed();
    t_limit();
    t_busy_inputs();
    t_emptied();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule